// File: doc/BRIEF.md
# Error Interrupt Aggregator with Wired and Doorbell Sources

This block gathers sixty-four error sources into one level interrupt toward a parent interrupt controller. The lowest twenty-one sources arrive on dedicated wires and are active-high level signals. The remaining forty-three have no wire. An upstream unit raises one of them by writing its source number to a doorbell register, and the source then stays pending as a one-shot event until software clears it.

Both kinds of source share one pending (cause) register and one mask register per group of thirty-two. Source n lives in group n/32 at bit n%32. The cause words are at byte offsets 0x00 and 0x04, the mask words at 0x20 and 0x24, and the doorbell at 0x30. Software clears a pending source by writing a one to its cause bit. It disables a source by setting its mask bit. When the output fires, software scans both cause words from the lowest bit upward to find the active sources.

The register bus is minimal. A write takes effect on the clock edge at which the write strobe is high. Read data is a combinational function of the address.

Top module: `erragg_top`

## Requirements
- R1: After reset every cause bit is 0, every mask bit is 1, and the interrupt output is low.
- R2: Source n is reported in the cause word at offset 0x00 + 4*(n/32), bit n%32, and masked by the mask word at offset 0x20 + 4*(n/32), same bit.
- R3: Writing a cause word clears exactly those pending bits written as 1. Bits written as 0 keep their value.
- R4: A mask word reads back as last written. A mask bit of 1 keeps its source out of the interrupt output and a mask bit of 0 lets it through. Masking does not stop the cause bit from being latched.
- R5: While wired input i (0 to 20) is high at a clock edge, cause bit i is 1 after that edge. It stays 1 after the input falls, until it is cleared.
- R6: A write of value v with 21 <= v <= 63 to offset 0x30 sets cause bit v, and only that bit. The bit stays set until cleared.
- R7: A doorbell write whose full 32-bit value lies outside 21..63 sets no cause bit.
- R8: When a clear of a cause bit and a new assertion of the same source occur on the same edge, the bit stays 1.
- R9: The interrupt output is a register. After each edge it equals the OR over all 64 sources of (cause AND NOT mask) as held before that edge, so it lags a cause or mask change by one cycle.
- R10: Reads at any offset other than 0x00, 0x04, 0x20 and 0x24 return zero, including 0x30. Writes at any offset other than those and 0x30 change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wired_lvl | input | 21 | Active-high level inputs for sources 0 to 20 |
| reg_addr | input | 8 | Register byte offset for reads and writes |
| reg_wr | input | 1 | Write strobe, one write per cycle it is high |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, zero for unused offsets |
| irq_out | output | 1 | Registered combined interrupt toward the parent |

## Verification
The doorbell is swept over every value from 0 to 71 and over values whose low six bits name a valid source while the upper bits do not. This separates a correct full-width range check from a truncating one, and shows whether each valid number lands in the right word and bit. Each wired input is raised alone, dropped and cleared, which shows level latching, stickiness and the bit mapping. Clearing a wire while it is still high separates set-over-clear priority from clear priority. Mask toggles around a single pending doorbell and a single wired source check both the gating and the one-cycle output latency. Stray writes to unused, misaligned and doorbell-neighbour offsets show that no other state is touched.

// File: rtl/erragg_pkg.sv
package erragg_pkg;

    localparam int REG_W     = 32;
    localparam int ADDR_W    = 8;
    localparam int NUM_SRC   = 64;
    localparam int NUM_WIRED = 21;
    localparam int NUM_GRP   = NUM_SRC / REG_W;
    localparam int GRP_W     = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1;
    localparam int SRC_IDX_W = $clog2(NUM_SRC);

    localparam logic [ADDR_W-1:0] CAUSE_BASE = 8'h00;
    localparam logic [ADDR_W-1:0] MASK_BASE  = 8'h20;
    localparam logic [ADDR_W-1:0] BELL_OFS   = 8'h30;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_CAUSE,
        SEL_MASK,
        SEL_BELL
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e         sel;
        logic [GRP_W-1:0] grp;
    } reg_dec_t;

    function automatic reg_dec_t decode_addr(input logic [ADDR_W-1:0] a);
        reg_dec_t d;
        d.sel = SEL_NONE;
        d.grp = '0;
        for (int g = 0; g < NUM_GRP; g++) begin
            if (a == CAUSE_BASE + ADDR_W'(4 * g)) begin
                d.sel = SEL_CAUSE;
                d.grp = GRP_W'(g);
            end
            if (a == MASK_BASE + ADDR_W'(4 * g)) begin
                d.sel = SEL_MASK;
                d.grp = GRP_W'(g);
            end
        end
        if (a == BELL_OFS) begin
            d.sel = SEL_BELL;
        end
        return d;
    endfunction

    function automatic logic bell_in_range(input logic [REG_W-1:0] v);
        return (v >= REG_W'(NUM_WIRED)) && (v < REG_W'(NUM_SRC));
    endfunction

endpackage

// File: rtl/erragg_regif.sv
module erragg_regif
    import erragg_pkg::*;
(
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_wr,
    input  logic [REG_W-1:0]   reg_wdata,
    input  logic [NUM_SRC-1:0] cause_all,
    input  logic [NUM_SRC-1:0] mask_all,
    output logic [NUM_SRC-1:0] clr_all,
    output logic [NUM_SRC-1:0] bell_set,
    output logic [NUM_GRP-1:0] mask_we,
    output logic [REG_W-1:0]   reg_rdata
);

    reg_dec_t dec;

    always_comb begin
        dec = decode_addr(reg_addr);
    end

    // Write side: per-group clear strobes and mask write enables.
    always_comb begin
        clr_all = '0;
        mask_we = '0;
        for (int g = 0; g < NUM_GRP; g++) begin
            if (reg_wr && dec.sel == SEL_CAUSE && int'(dec.grp) == g) begin
                clr_all[g*REG_W +: REG_W] = reg_wdata;
            end
            if (reg_wr && dec.sel == SEL_MASK && int'(dec.grp) == g) begin
                mask_we[g] = 1'b1;
            end
        end
    end

    // Doorbell: one-hot set for an in-range source number, nothing otherwise.
    always_comb begin
        bell_set = '0;
        if (reg_wr && dec.sel == SEL_BELL && bell_in_range(reg_wdata)) begin
            for (int s = NUM_WIRED; s < NUM_SRC; s++) begin
                if (reg_wdata[SRC_IDX_W-1:0] == SRC_IDX_W'(s)) begin
                    bell_set[s] = 1'b1;
                end
            end
        end
    end

    // Read side: only cause and mask words are visible.
    always_comb begin
        reg_rdata = '0;
        case (dec.sel)
            SEL_CAUSE: reg_rdata = cause_all[int'(dec.grp)*REG_W +: REG_W];
            SEL_MASK:  reg_rdata = mask_all[int'(dec.grp)*REG_W +: REG_W];
            default:   reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/erragg_group.sv
module erragg_group
    import erragg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] set_bits,
    input  logic [REG_W-1:0] clr_bits,
    input  logic             mask_we,
    input  logic [REG_W-1:0] mask_wdata,
    output logic [REG_W-1:0] cause_q,
    output logic [REG_W-1:0] mask_q
);

    logic [REG_W-1:0] cause_d;

    // A new assertion wins over a clear on the same edge.
    always_comb begin
        cause_d = (cause_q & ~clr_bits) | set_bits;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cause_q <= '0;
            mask_q  <= '1;
        end else begin
            cause_q <= cause_d;
            if (mask_we) begin
                mask_q <= mask_wdata;
            end
        end
    end

endmodule

// File: rtl/erragg_irq.sv
module erragg_irq
    import erragg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] cause_all,
    input  logic [NUM_SRC-1:0] mask_all,
    output logic               irq_out
);

    logic [NUM_GRP-1:0] grp_hit;

    always_comb begin
        for (int g = 0; g < NUM_GRP; g++) begin
            grp_hit[g] = |(cause_all[g*REG_W +: REG_W] & ~mask_all[g*REG_W +: REG_W]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_out <= 1'b0;
        end else begin
            irq_out <= |grp_hit;
        end
    end

endmodule

// File: rtl/erragg_top.sv
module erragg_top
    import erragg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_WIRED-1:0] wired_lvl,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic                 reg_wr,
    input  logic [REG_W-1:0]     reg_wdata,
    output logic [REG_W-1:0]     reg_rdata,
    output logic                 irq_out
);

    logic [NUM_SRC-1:0] cause_all;
    logic [NUM_SRC-1:0] mask_all;
    logic [NUM_SRC-1:0] clr_all;
    logic [NUM_SRC-1:0] bell_set;
    logic [NUM_SRC-1:0] set_all;
    logic [NUM_GRP-1:0] mask_we;

    erragg_regif regif_i (
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .cause_all (cause_all),
        .mask_all  (mask_all),
        .clr_all   (clr_all),
        .bell_set  (bell_set),
        .mask_we   (mask_we),
        .reg_rdata (reg_rdata)
    );

    always_comb begin
        set_all = bell_set;
        set_all[NUM_WIRED-1:0] = set_all[NUM_WIRED-1:0] | wired_lvl;
    end

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        erragg_group grp_i (
            .clk        (clk),
            .rst        (rst),
            .set_bits   (set_all[g*REG_W +: REG_W]),
            .clr_bits   (clr_all[g*REG_W +: REG_W]),
            .mask_we    (mask_we[g]),
            .mask_wdata (reg_wdata),
            .cause_q    (cause_all[g*REG_W +: REG_W]),
            .mask_q     (mask_all[g*REG_W +: REG_W])
        );
    end

    erragg_irq irq_i (
        .clk       (clk),
        .rst       (rst),
        .cause_all (cause_all),
        .mask_all  (mask_all),
        .irq_out   (irq_out)
    );

endmodule

// File: rtl/erragg_chk.sv
module erragg_chk
    import erragg_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_WIRED-1:0] wired_lvl,
    input logic [ADDR_W-1:0]    reg_addr,
    input logic                 reg_wr,
    input logic [REG_W-1:0]     reg_wdata,
    input logic                 irq_out,
    input logic [NUM_SRC-1:0]   cause_all,
    input logic [NUM_SRC-1:0]   mask_all
);

    // R9: output follows the masked pending state one cycle later.
    a_r9_irq_lag: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_out == $past(|(cause_all & ~mask_all))));

    // R5: every wire high at an edge shows as pending after it.
    a_r5_wired_latch: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((cause_all[NUM_WIRED-1:0] & $past(wired_lvl)) == $past(wired_lvl)));

    // R6: an in-range doorbell write leaves its source pending.
    a_r6_bell_sets: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == BELL_OFS && bell_in_range(reg_wdata))
        |=> cause_all[$past(reg_wdata[SRC_IDX_W-1:0])]);

    // R6, R7: message sources rise at most one per cycle.
    a_r6_one_bell_bit: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $onehot0(cause_all[NUM_SRC-1:NUM_WIRED] & ~$past(cause_all[NUM_SRC-1:NUM_WIRED])));

    // R4, R10: mask words change only on a write to a mask offset.
    a_r4_mask_hold: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr && (reg_addr == MASK_BASE || reg_addr == MASK_BASE + 8'h04))
        |=> $stable(mask_all));

endmodule

bind erragg_top erragg_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .wired_lvl (wired_lvl),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .irq_out   (irq_out),
    .cause_all (cause_all),
    .mask_all  (mask_all)
);

// File: tb/erragg_top_tb_top.sv
module erragg_top_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [20:0] wired_lvl;
    logic [7:0]  reg_addr;
    logic        reg_wr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        irq_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    erragg_top dut_i (
        .clk       (clk),
        .rst       (rst),
        .wired_lvl (wired_lvl),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_out   (irq_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Write lands on the next rising edge; returns at the negedge after it.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
        reg_addr  = 8'h3C;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic expect_cause(input string req, input logic [63:0] e);
        logic [31:0] v;
        rd(8'h00, v); check(req, v, e[31:0]);
        rd(8'h04, v); check(req, v, e[63:32]);
    endtask

    initial begin
        logic [31:0] v;
        logic [63:0] e;
        logic [31:0] odd [4];
        logic [7:0]  stray [10];
        rst = 1'b1; wired_lvl = '0; reg_addr = 8'h3C; reg_wr = 1'b0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        expect_cause("R1 cause after reset", 64'h0);
        rd(8'h20, v); check("R1 mask0 after reset", v, 32'hFFFF_FFFF);
        rd(8'h24, v); check("R1 mask1 after reset", v, 32'hFFFF_FFFF);
        check("R1 irq after reset", {31'b0, irq_out}, 32'h0);

        // R6 R7 R2 R3: doorbell sweep over 0..71
        for (int n = 0; n < 72; n++) begin
            wr(8'h30, 32'(n));
            e = (n >= 21 && n < 64) ? (64'h1 << n) : 64'h0;
            expect_cause((n >= 21 && n < 64) ? "R6 R2 doorbell sets bit" : "R7 doorbell ignored", e);
            @(negedge clk);
            check("R4 masked doorbell keeps irq low", {31'b0, irq_out}, 32'h0);
            if (e != 64'h0) begin
                wr(8'h00 + 8'(4 * (n / 32)), 32'h1 << (n % 32));
                expect_cause("R3 clear doorbell source", 64'h0);
            end
        end

        // R7: upper bits set while low six bits name a valid source
        odd[0] = 32'h0000_011E; odd[1] = 32'h0000_0055;
        odd[2] = 32'hFFFF_FFFF; odd[3] = 32'h8000_0028;
        for (int k = 0; k < 4; k++) begin
            wr(8'h30, odd[k]);
            expect_cause("R7 out-of-range doorbell ignored", 64'h0);
        end

        // R3: zero bits leave pending sources alone
        wr(8'h30, 32'd50);
        wr(8'h30, 32'd22);
        wr(8'h04, 32'h0);
        wr(8'h00, 32'h0);
        expect_cause("R3 write zero keeps bits", (64'h1 << 50) | (64'h1 << 22));
        wr(8'h00, 32'h1 << 22);
        expect_cause("R3 clear only written bit", 64'h1 << 50);
        wr(8'h04, 32'h1 << 18);
        expect_cause("R3 clear upper bit", 64'h0);

        // R5: each wire latched, sticky, cleared
        for (int i = 0; i < 21; i++) begin
            wired_lvl = 21'(1) << i;
            @(negedge clk);
            expect_cause("R5 wire latched", 64'h1 << i);
            wired_lvl = '0;
            @(negedge clk);
            expect_cause("R5 wire sticky after drop", 64'h1 << i);
            wr(8'h00, 32'h1 << i);
            expect_cause("R5 wire cleared", 64'h0);
        end

        // R8: clear while wire still high
        wired_lvl = 21'(1) << 5;
        @(negedge clk);
        wr(8'h00, 32'h1 << 5);
        expect_cause("R8 set wins over clear", 64'h1 << 5);
        wired_lvl = '0;
        wr(8'h00, 32'h1 << 5);
        expect_cause("R8 clear after drop", 64'h0);

        // R4: mask readback
        wr(8'h20, 32'hA5A5_0F0F);
        rd(8'h20, v); check("R4 mask0 readback", v, 32'hA5A5_0F0F);
        wr(8'h24, 32'h0F0F_A5A5);
        rd(8'h24, v); check("R4 mask1 readback", v, 32'h0F0F_A5A5);
        wr(8'h20, 32'hFFFF_FFFF);
        wr(8'h24, 32'hFFFF_FFFF);

        // R9 R4: gating and one-cycle latency, doorbell source 40
        wr(8'h30, 32'd40);
        @(negedge clk);
        check("R4 masked source no irq", {31'b0, irq_out}, 32'h0);
        wr(8'h24, ~(32'h1 << 8));
        check("R9 irq one cycle late on unmask", {31'b0, irq_out}, 32'h0);
        @(negedge clk);
        check("R9 irq after unmask", {31'b0, irq_out}, 32'h1);
        wr(8'h24, 32'hFFFF_FFFF);
        check("R9 irq still high right after mask", {31'b0, irq_out}, 32'h1);
        @(negedge clk);
        check("R4 irq dropped by mask", {31'b0, irq_out}, 32'h0);
        wr(8'h24, ~(32'h1 << 8));
        @(negedge clk);
        wr(8'h04, 32'h1 << 8);
        check("R9 irq lag on clear", {31'b0, irq_out}, 32'h1);
        @(negedge clk);
        check("R9 irq low after clear", {31'b0, irq_out}, 32'h0);
        wr(8'h24, 32'hFFFF_FFFF);

        // R9: wired source path
        wr(8'h20, ~(32'h1 << 3));
        wired_lvl = 21'(1) << 3;
        @(negedge clk);
        check("R9 wired irq lag", {31'b0, irq_out}, 32'h0);
        @(negedge clk);
        check("R9 wired irq high", {31'b0, irq_out}, 32'h1);
        wired_lvl = '0;
        wr(8'h00, 32'h1 << 3);
        @(negedge clk);
        check("R9 wired irq low after clear", {31'b0, irq_out}, 32'h0);
        wr(8'h20, 32'hFFFF_FFFF);

        // R10: stray offsets
        stray[0] = 8'h08; stray[1] = 8'h10; stray[2] = 8'h1C; stray[3] = 8'h28;
        stray[4] = 8'h2C; stray[5] = 8'h34; stray[6] = 8'h01; stray[7] = 8'h21;
        stray[8] = 8'hFC; stray[9] = 8'h31;
        for (int k = 0; k < 10; k++) begin
            wr(stray[k], 32'hFFFF_FFFF);
            rd(stray[k], v); check("R10 unused offset reads zero", v, 32'h0);
        end
        expect_cause("R10 stray writes left cause", 64'h0);
        rd(8'h20, v); check("R10 stray writes left mask0", v, 32'hFFFF_FFFF);
        rd(8'h24, v); check("R10 stray writes left mask1", v, 32'hFFFF_FFFF);
        wr(8'h30, 32'd33);
        rd(8'h30, v); check("R10 doorbell reads zero", v, 32'h0);
        expect_cause("R6 R2 doorbell 33 in word one", 64'h1 << 33);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule